// File: doc/BRIEF.md
# Dual-Mode SRAM Line Cache Front-End

This block places a 16 Kbit on-chip SRAM between a host and a slower backing memory whose latency is not known in advance. Every address names one 64-bit line. A level input picks one of two ways of using the SRAM. In cache mode the SRAM is a direct-mapped, tag-checked cache for random reads and writes. In buffer mode the SRAM is a tagless window: a prefetch command copies a run of consecutive lines from backing memory into it, and reads that fall inside the window are then served from the SRAM alone, as a display refresh engine would need.

Writes always pass through to backing memory. A cache-mode write that hits, or a buffer-mode write inside the window, also updates the SRAM copy. A read miss stalls the host (ready low) until the backing data returns. Any change of mode empties the SRAM: all tags become invalid and the buffer window becomes empty.

The control is a single state machine with these states. `ST_IDLE` accepts requests and commands. `ST_RD_REQ` presents a backing read and moves to `ST_RD_WAIT` when it is accepted. `ST_RD_WAIT` returns to `ST_IDLE` when the data arrives. `ST_WR_REQ` presents a write-through and returns to `ST_IDLE` when it is accepted. `ST_PF_REQ` presents one prefetch read and moves to `ST_PF_WAIT` when it is accepted. `ST_PF_WAIT` goes back to `ST_PF_REQ` for the next line, or to `ST_IDLE` after the last line. From `ST_IDLE`, a mode mismatch takes a flush cycle and stays in `ST_IDLE`. A prefetch command in buffer mode goes to `ST_PF_REQ`. A write goes to `ST_WR_REQ`. A read that misses goes to `ST_RD_REQ`. A read that hits stays in `ST_IDLE`.

Top module: `sfc_dual_mode_cache`

## Requirements
- R1: After reset, req_ready is 1 and both rsp_valid and mem_valid are 0.
- R2: In cache mode (mode_sel=0), a read that misses issues exactly one backing read of that address. The response carries the backing data, and the line is filled into the slot given by the low log2(LINES) address bits.
- R3: A cache-mode read hit gives rsp_valid and the stored line in the first cycle after the request is accepted, with no backing access.
- R4: Two addresses with equal low log2(LINES) bits and different upper bits share one slot. Reading one evicts the other, so the other misses on its next read.
- R5: Every write is accepted by backing memory exactly once, with rsp_valid one cycle after that acceptance. A cache-mode write hit updates the SRAM copy. A write miss does not allocate, so the next read of that address misses.
- R6: While a backing transfer is outstanding, req_ready is 0. mem_valid, mem_addr and mem_write hold steady until mem_ready is seen.
- R7: Changing mode_sel invalidates all cached lines and the buffer window. A line cached before a round trip to buffer mode misses afterwards.
- R8: In buffer mode (mode_sel=1), a one-cycle pf_start issues PF_LINES backing reads of pf_base, pf_base+1, and so on. req_ready stays 0 until the last line has been stored.
- R9: In buffer mode, a read at pf_base+k with k < PF_LINES, after a prefetch, is answered from SRAM one cycle after acceptance with no backing access.
- R10: In buffer mode, a read outside the window is forwarded to backing memory and is not stored. A repeat of that read is forwarded again.
- R11: In buffer mode, a write inside the window goes to backing memory and also updates the SRAM copy that later window reads return.
- R12: pf_start has no effect in cache mode: no backing read is issued and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = cache mode, 1 = buffer mode |
| pf_start | input | 1 | Prefetch command pulse (buffer mode only) |
| pf_base | input | ADDR_W | First line address of the prefetch window |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data, valid with rsp_valid on reads |
| mem_valid | output | 1 | Backing request valid |
| mem_ready | input | 1 | Backing request accepted |
| mem_write | output | 1 | Backing request is a write |
| mem_addr | output | ADDR_W | Backing line address |
| mem_wdata | output | 64 | Backing write data |
| mem_rvalid | input | 1 | Backing read data valid |
| mem_rdata | input | 64 | Backing read data |

## Verification
The bench builds the block with ADDR_W=8, LINES=16 and PF_LINES=8. With 16 slots, addresses 0x13 and 0x23 alias, which makes tag conflicts reachable with small constants. An 8-line window lets one prefetch and the boundary at pf_base+PF_LINES both be reached within a few hundred cycles. The backing model adds a fixed three-cycle delay on both the request acceptance and the read data, so the stall and hold behaviour is visible for several cycles.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int LINE_W = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_PF_REQ,
        ST_PF_WAIT
    } sfc_state_e;
endpackage

// File: rtl/sfc_line_store.sv
module sfc_line_store #(
    parameter int LINES = 256,
    parameter int W     = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/sfc_tag_store.sv
module sfc_tag_store #(
    parameter int LINES = 256,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             fill,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            valid_q <= '0;
        end else if (fill) begin
            valid_q[fill_idx] <= 1'b1;
        end
        if (fill) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    assign hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

    // R7: a flush leaves no valid line behind
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));
endmodule

// File: rtl/sfc_dual_mode_cache.sv
module sfc_dual_mode_cache
    import sfc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LINES    = 256,
    parameter int PF_LINES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              pf_start,
    input  logic [ADDR_W-1:0] pf_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [ADDR_W:0] WIN_SPAN = (ADDR_W+1)'(PF_LINES);
    localparam logic [CNT_W-1:0] PF_LAST = CNT_W'(PF_LINES - 1);

    sfc_state_e state_q, state_d;
    logic              mode_q;
    logic              win_valid_q;
    logic [ADDR_W-1:0] win_base_q;
    logic [CNT_W-1:0]  pf_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [63:0]       wdata_q;
    logic              rsp_valid_q, rsp_sram_q;
    logic [63:0]       rsp_data_q;

    logic              mode_chg, pf_go, accept, tag_hit, sram_hit;
    logic [ADDR_W-1:0] win_off;
    logic              win_in;
    logic [IDX_W-1:0]  slot;
    logic              st_we, st_re, tag_fill, flush;
    logic [IDX_W-1:0]  st_waddr;
    logic [63:0]       st_wdata, st_rdata;

    // request decode
    assign mode_chg = (mode_sel != mode_q);
    assign pf_go    = (state_q == ST_IDLE) && !mode_chg && mode_q && pf_start;
    assign win_off  = req_addr - win_base_q;
    assign win_in   = win_valid_q && ({1'b0, win_off} < WIN_SPAN);
    assign sram_hit = mode_q ? win_in : tag_hit;
    assign slot     = mode_q ? win_off[IDX_W-1:0] : req_addr[IDX_W-1:0];
    assign accept   = req_valid && req_ready;
    assign flush    = (state_q == ST_IDLE) && mode_chg;

    sfc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_all  (flush),
        .fill     (tag_fill),
        .fill_idx (addr_q[IDX_W-1:0]),
        .fill_tag (addr_q[ADDR_W-1:IDX_W]),
        .look_idx (req_addr[IDX_W-1:0]),
        .look_tag (req_addr[ADDR_W-1:IDX_W]),
        .hit      (tag_hit)
    );

    sfc_line_store #(.LINES(LINES), .W(LINE_W)) u_lines (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .re    (st_re),
        .raddr (slot),
        .rdata (st_rdata)
    );

    // SRAM write port: write hit, read fill, prefetch fill
    always_comb begin
        st_we    = 1'b0;
        st_waddr = slot;
        st_wdata = req_wdata;
        tag_fill = 1'b0;
        if (accept && req_write && sram_hit) begin
            st_we = 1'b1;
        end else if (state_q == ST_RD_WAIT && mem_rvalid && !mode_q) begin
            st_we    = 1'b1;
            tag_fill = 1'b1;
            st_waddr = addr_q[IDX_W-1:0];
            st_wdata = mem_rdata;
        end else if (state_q == ST_PF_WAIT && mem_rvalid) begin
            st_we    = 1'b1;
            st_waddr = pf_cnt_q[IDX_W-1:0];
            st_wdata = mem_rdata;
        end
    end
    assign st_re = accept && !req_write && sram_hit;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pf_go)                        state_d = ST_PF_REQ;
                else if (accept && req_write)     state_d = ST_WR_REQ;
                else if (accept && !sram_hit)     state_d = ST_RD_REQ;
            end
            ST_RD_REQ:  if (mem_ready)  state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) state_d = ST_IDLE;
            ST_WR_REQ:  if (mem_ready)  state_d = ST_IDLE;
            ST_PF_REQ:  if (mem_ready)  state_d = ST_PF_WAIT;
            ST_PF_WAIT: if (mem_rvalid) state_d = (pf_cnt_q == PF_LAST) ? ST_IDLE : ST_PF_REQ;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= 1'b0;
            win_valid_q <= 1'b0;
            win_base_q  <= '0;
            pf_cnt_q    <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_sram_q  <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (flush) begin
                mode_q      <= mode_sel;
                win_valid_q <= 1'b0;
            end
            if (pf_go) begin
                win_valid_q <= 1'b0;
                win_base_q  <= pf_base;
                pf_cnt_q    <= '0;
            end
            if (state_q == ST_PF_WAIT && mem_rvalid) begin
                pf_cnt_q <= pf_cnt_q + 1'b1;
                if (pf_cnt_q == PF_LAST) win_valid_q <= 1'b1;
            end
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_RD_WAIT && mem_rvalid) rsp_data_q <= mem_rdata;
            rsp_sram_q  <= st_re;
            rsp_valid_q <= st_re
                        || (state_q == ST_RD_WAIT && mem_rvalid)
                        || (state_q == ST_WR_REQ && mem_ready);
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE) && !mode_chg && !(mode_q && pf_start);
        mem_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ) || (state_q == ST_PF_REQ);
        mem_write = (state_q == ST_WR_REQ);
        mem_addr  = (state_q == ST_PF_REQ) ? win_base_q + ADDR_W'(pf_cnt_q) : addr_q;
        mem_wdata = wdata_q;
        rsp_valid = rsp_valid_q;
        rsp_rdata = rsp_sram_q ? st_rdata : rsp_data_q;
    end

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    assert_busy_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    // R3 / R5: every completion pulse has a cause one cycle earlier
    assert_rsp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept) || $past(mem_rvalid) || $past(mem_valid && mem_ready && mem_write));

    assert_pf_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PF_WAIT) && mem_rvalid && (pf_cnt_q == PF_LAST) |=> win_valid_q && req_ready == !mode_chg);
endmodule

// File: tb/sim_sfc_dual_mode_cache.sv
module sim_sfc_dual_mode_cache;
    localparam int AW = 8;
    localparam int PF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_sel = 1'b0, pf_start = 1'b0;
    logic [AW-1:0] pf_base = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_valid, mem_write;
    logic [63:0] rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] bmem [256];
    int n_rd = 0, n_wr = 0, lat = 3;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    sfc_dual_mode_cache #(.ADDR_W(AW), .LINES(16), .PF_LINES(PF)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pf_start(pf_start), .pf_base(pf_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // backing memory model with fixed delay
    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = {32'hD00D_0000 | 32'(i), 32'(i * 7)};
        forever begin
            @(negedge clk);
            mem_ready  = 1'b0;
            mem_rvalid = 1'b0;
            if (rst_n && mem_valid) begin
                repeat (lat) @(negedge clk);
                mem_ready = 1'b1;
                if (mem_write) begin
                    bmem[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    logic [AW-1:0] ra;
                    ra = mem_addr;
                    n_rd++;
                    @(negedge clk);
                    mem_ready = 1'b0;
                    repeat (lat) @(negedge clk);
                    mem_rdata  = bmem[ra];
                    mem_rvalid = 1'b1;
                end
            end
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input bit exp_hit, input string req);
        int r0, cyc;
        logic [63:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        while (!req_ready) @(negedge clk);
        r0 = n_rd; exp = bmem[a];
        @(negedge clk);
        req_valid = 1'b0;
        if (!exp_hit) chk(req_ready == 1'b0, "R6 stall on miss", 64'(req_ready), 64'd0);
        cyc = 1;
        while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
        chk(rsp_valid && rsp_rdata == exp, req, rsp_rdata, exp);
        if (exp_hit) begin
            chk(cyc == 1, {req, " latency"}, 64'(cyc), 64'd1);
            chk(n_rd == r0, {req, " no backing read"}, 64'(n_rd - r0), 64'd0);
        end else begin
            chk(n_rd == r0 + 1, {req, " one backing read"}, 64'(n_rd - r0), 64'd1);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input string req);
        int w0, cyc;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        w0 = n_wr;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
        chk(rsp_valid && n_wr == w0 + 1, req, 64'(n_wr - w0), 64'd1);
        chk(bmem[a] == d, {req, " backing data"}, bmem[a], d);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode_sel = m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_valid == 1'b0, "R1 reset outputs",
            {61'd0, req_ready, rsp_valid, mem_valid}, 64'd4);
    endtask

    task automatic t_cache;
        do_read(8'h13, 1'b0, "R2 cache miss fill");
        do_read(8'h13, 1'b1, "R3 cache hit");
        do_read(8'h23, 1'b0, "R4 conflicting tag misses");
        do_read(8'h13, 1'b0, "R4 evicted line misses");
        do_write(8'h13, 64'h1111_2222_3333_4444, "R5 write hit through");
        do_read(8'h13, 1'b1, "R5 write hit updated copy");
        do_write(8'h45, 64'h5555_6666_7777_8888, "R5 write miss through");
        do_read(8'h45, 1'b0, "R5 no write allocate");
    endtask

    task automatic t_pf_ignored;
        int r0;
        r0 = n_rd;
        @(negedge clk); pf_base = 8'h60; pf_start = 1'b1;
        @(negedge clk); pf_start = 1'b0;
        chk(req_ready == 1'b1, "R12 pf_start ignored ready", 64'(req_ready), 64'd1);
        repeat (10) @(negedge clk);
        chk(n_rd == r0, "R12 pf_start no backing reads", 64'(n_rd - r0), 64'd0);
    endtask

    task automatic t_buffer;
        int r0, cyc;
        set_mode(1'b1);
        do_read(8'h40, 1'b0, "R10 empty window forwards");
        r0 = n_rd;
        @(negedge clk); pf_base = 8'h40; pf_start = 1'b1;
        @(negedge clk); pf_start = 1'b0;
        chk(req_ready == 1'b0, "R8 busy during prefetch", 64'(req_ready), 64'd0);
        cyc = 0;
        while (!req_ready && cyc < 1000) begin @(negedge clk); cyc++; end
        chk(n_rd - r0 == PF, "R8 prefetch read count", 64'(n_rd - r0), 64'(PF));
        do_read(8'h40, 1'b1, "R9 window first line");
        do_read(8'h47, 1'b1, "R9 window last line");
        do_read(8'h48, 1'b0, "R10 outside window forwarded");
        do_read(8'h48, 1'b0, "R10 outside window not stored");
        do_read(8'h3F, 1'b0, "R10 below window forwarded");
        do_write(8'h42, 64'hABCD_EF01_2345_6789, "R11 window write through");
        do_read(8'h42, 1'b1, "R11 window copy updated");
    endtask

    task automatic t_mode_flush;
        set_mode(1'b0);
        do_read(8'h13, 1'b0, "R7 mode change invalidates");
        do_read(8'h13, 1'b1, "R7 refill after flush");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cache();
        t_pf_ignored();
        t_buffer();
        t_mode_flush();
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule